// File: doc/BRIEF.md
# Oversampled PCM Bit Recovery with Glitch Rejection

This block takes a single-wire NRZ PCM stream that is already at logic levels and carries no clock of its own. It samples the line with a clock twenty times the bit rate, for example 39.3216 MHz against 1.96608 MHz. It recovers the bits from the data transitions alone.

The raw line first passes through a two-flop synchroniser. A hold-time filter follows it. The filter lets a new level through only once that level has been seen on five consecutive sampling clocks, so a shorter pulse is treated as interference and dropped.

A divide-by-20 phase counter restarts on every clean transition of the filtered level. It samples the filtered level at mid-bit and emits the recovered bit with a one-clock valid strobe. Between transitions the counter free-runs, so a long run of equal bits still yields one strobe every twenty clocks. A signal-present flag rises on each filtered transition and falls after a set number of bit periods without one.

The output is a stream, but it has no ready input. The line cannot be paused, so the consumer must take every strobe in the cycle it appears. Back-pressure is not supported, and a strobe that is not taken is lost.

Top module: `pcm_bit_recover`

## Requirements
- R1: While rst_n is low and on the first sampling clock after it is released, bit_valid, bit_data and sig_present are all 0.
- R2: A change of the synchronised line level that lasts fewer than HOLD (default 5) consecutive sampling clocks is discarded: it changes neither bit_data nor sig_present.
- R3: A level that holds for HOLD consecutive synchronised samples becomes the filtered level on the HOLD-th of those clocks.
- R4: bit_valid is high for exactly one clock at a time. When there is no filtered transition, consecutive strobes are exactly OSR (default 20) clocks apart.
- R5: Each filtered transition restarts the bit phase. The first strobe after an accepted raw input change comes on the 19th rising edge counted from the edge that first samples the change: 2 synchroniser clocks, 5 filter clocks, and the mid-bit point at phase count 10.
- R6: On a strobe, bit_data carries the filtered level at mid-bit and holds it until the next strobe. A stream of 20-clock bits is recovered as exactly one strobe per bit, with bit value 1 for a high line.
- R7: sig_present goes to 1 one clock after a filtered transition is registered. It returns to 0 after IDLE_BITS (default 8) full bit periods pass with no transition.
- R8: Bits whose length varies between 19 and 21 sampling clocks, in runs of up to three equal bits, are still recovered one strobe per bit with the correct value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, OSR times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcm_in | input | 1 | Raw NRZ PCM line at logic level |
| bit_data | output | 1 | Recovered bit, updated on each strobe |
| bit_valid | output | 1 | One-clock strobe marking a new recovered bit |
| sig_present | output | 1 | High while transitions keep arriving on the line |

## Verification
The bench uses several kinds of stimulus, and each one separates a different class of fault.

- Isolated pulses of four and five samples on a quiet line separate a correct hold threshold from one that is off by one.
- A long constant run shows that the divider free-runs at the right spacing. The following silence times the drop of the signal-present flag.
- A fixed 16-bit word of exact 20-clock bits shows whether the mid-bit sample lands on the right bit.
- A random stream with 19-to-21-clock bits separates phase realignment on every transition from a divider that never realigns.

Throughout all of these, a behavioural model predicts all three outputs on every clock.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
  // default oversampling ratio (sampling clocks per bit)
  localparam int unsigned PCM_OSR_DEF  = 20;
  // default number of identical samples a new level must hold
  localparam int unsigned PCM_HOLD_DEF = 5;
  // default bit periods without a transition before the line is called silent
  localparam int unsigned PCM_IDLE_DEF = 8;

  typedef struct packed {
    logic valid;
    logic data;
  } pcm_bit_t;
endpackage

// File: rtl/pcm_sync_chain.sv
module pcm_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pcm_hold_filter.sv
module pcm_hold_filter #(
  parameter int unsigned HOLD = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic lvl_out
);
  localparam int unsigned CW = (HOLD > 2) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] run_q;
  logic          lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (lvl_in == lvl_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      lvl_q <= lvl_in;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign lvl_out = lvl_q;
endmodule

// File: rtl/pcm_phase_timer.sv
module pcm_phase_timer #(
  parameter int unsigned OSR = 20,
  localparam int unsigned PW = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl,
  output logic          trans,
  output logic          wrap,
  output logic [PW-1:0] phase,
  output logic          bit_valid,
  output logic          bit_data
);
  localparam logic [PW-1:0] MID_C  = PW'(OSR / 2);
  localparam logic [PW-1:0] LAST_C = PW'(OSR - 1);

  logic          lvl_q;
  logic [PW-1:0] phase_q;
  logic          strobe;

  assign trans  = lvl ^ lvl_q;
  assign wrap   = (phase_q == LAST_C);
  assign strobe = (phase_q == MID_C) && !trans;
  assign phase  = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q     <= 1'b0;
      phase_q   <= '0;
      bit_valid <= 1'b0;
      bit_data  <= 1'b0;
    end else begin
      lvl_q     <= lvl;
      bit_valid <= strobe;
      if (strobe) bit_data <= lvl;
      if (trans || wrap) phase_q <= '0;
      else               phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_activity.sv
module pcm_activity #(
  parameter int unsigned IDLE_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trans,
  input  logic wrap,
  output logic present
);
  localparam int unsigned IW = $clog2(IDLE_BITS + 1);
  localparam logic [IW-1:0] LAST_C = IW'(IDLE_BITS - 1);

  logic [IW-1:0] idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present <= 1'b0;
      idle_q  <= '0;
    end else if (trans) begin
      present <= 1'b1;
      idle_q  <= '0;
    end else if (wrap && present) begin
      if (idle_q == LAST_C) present <= 1'b0;
      else                  idle_q  <= idle_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_bit_recover.sv
module pcm_bit_recover
  import pcm_rx_pkg::*;
#(
  parameter int unsigned OSR       = PCM_OSR_DEF,
  parameter int unsigned HOLD      = PCM_HOLD_DEF,
  parameter int unsigned IDLE_BITS = PCM_IDLE_DEF,
  parameter int unsigned SYNC_FF   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pcm_in,
  output logic bit_data,
  output logic bit_valid,
  output logic sig_present
);
  localparam int unsigned PW = $clog2(OSR);

  logic          sync_lvl;
  logic          filt_lvl;
  logic          trans;
  logic          wrap;
  logic [PW-1:0] phase;
  pcm_bit_t      rec;

  pcm_sync_chain #(.STAGES(SYNC_FF)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .din (pcm_in),
    .dout (sync_lvl)
  );

  pcm_hold_filter #(.HOLD(HOLD)) u_filt (
    .clk (clk),
    .rst_n (rst_n),
    .lvl_in (sync_lvl),
    .lvl_out (filt_lvl)
  );

  pcm_phase_timer #(.OSR(OSR)) u_timer (
    .clk (clk),
    .rst_n (rst_n),
    .lvl (filt_lvl),
    .trans (trans),
    .wrap (wrap),
    .phase (phase),
    .bit_valid (rec.valid),
    .bit_data (rec.data)
  );

  pcm_activity #(.IDLE_BITS(IDLE_BITS)) u_act (
    .clk (clk),
    .rst_n (rst_n),
    .trans (trans),
    .wrap (wrap),
    .present (sig_present)
  );

  assign bit_valid = rec.valid;
  assign bit_data  = rec.data;
endmodule

// File: rtl/pcm_bit_recover_chk.sv
module pcm_bit_recover_chk #(
  parameter int unsigned OSR  = 20,
  parameter int unsigned HOLD = 5,
  localparam int unsigned PW  = $clog2(OSR)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_lvl,
  input logic          filt_lvl,
  input logic [PW-1:0] phase,
  input logic          bit_valid,
  input logic          sig_present
);
  logic [7:0] run_q;
  logic       filt_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      filt_prev <= 1'b0;
    end else begin
      filt_prev <= filt_lvl;
      if (filt_lvl != filt_prev)      run_q <= (sync_lvl != filt_lvl) ? 8'd1 : 8'd0;
      else if (sync_lvl == filt_lvl)  run_q <= '0;
      else if (run_q != 8'hFF)        run_q <= run_q + 8'd1;
    end
  end

  // R2 and R3: the filtered level flips only after HOLD differing samples
  a_r2_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_lvl != $past(filt_lvl)) |-> (run_q == 8'(HOLD)));

  // R5: a filtered transition restarts the bit phase
  a_r5_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_lvl != $past(filt_lvl)) |=> (phase == '0));

  // R7: a filtered transition marks the line present
  a_r7_present_set: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_lvl != $past(filt_lvl)) |=> sig_present);

  // R4: the strobe lasts a single clock
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);
endmodule

bind pcm_bit_recover pcm_bit_recover_chk #(.OSR(OSR), .HOLD(HOLD)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .sync_lvl (sync_lvl),
  .filt_lvl (filt_lvl),
  .phase (phase),
  .bit_valid (bit_valid),
  .sig_present (sig_present)
);

// File: tb/pcm_bit_recover_bench.sv
module pcm_bit_recover_bench;
  localparam int OSR  = 20;
  localparam int HOLD = 5;
  localparam int IDLE = 8;
  localparam int MID  = OSR / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pcm_in = 1'b0;
  logic bit_data, bit_valid, sig_present;

  int checks = 0;
  int fails = 0;
  bit cmp_en = 1'b0;
  bit cap_en = 1'b0;
  bit done = 1'b0;
  bit cap_q[$];

  always #2 clk = ~clk;

  pcm_bit_recover u_pcm_bit_recover (
    .clk (clk),
    .rst_n (rst_n),
    .pcm_in (pcm_in),
    .bit_data (bit_data),
    .bit_valid (bit_valid),
    .sig_present (sig_present)
  );

  // behavioural reference, written from the requirements
  bit m_s1, m_s2, m_f, m_fd, m_v, m_d, m_pres;
  int m_cnt, m_ph, m_idle;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_f = 0; m_fd = 0; m_v = 0; m_d = 0; m_pres = 0;
      m_cnt = 0; m_ph = 0; m_idle = 0;
    end else begin
      bit tr, wr, stb;
      tr  = (m_f != m_fd);
      wr  = (m_ph == OSR - 1);
      stb = (m_ph == MID) && !tr;
      m_v = stb;
      if (stb) m_d = m_f;
      if (tr) begin
        m_pres = 1; m_idle = 0;
      end else if (wr && m_pres) begin
        if (m_idle == IDLE - 1) m_pres = 0;
        else m_idle++;
      end
      m_ph = (tr || wr) ? 0 : m_ph + 1;
      m_fd = m_f;
      if (m_s2 == m_f) m_cnt = 0;
      else if (m_cnt == HOLD - 1) begin
        m_f = m_s2; m_cnt = 0;
      end else m_cnt++;
      m_s2 = m_s1;
      m_s1 = pcm_in;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check(bit_valid == m_v, "R4 R5 bit_valid vs model", bit_valid, m_v);
      check(bit_data == m_d, "R6 bit_data vs model", bit_data, m_d);
      check(sig_present == m_pres, "R7 sig_present vs model", sig_present, m_pres);
    end
    if (cap_en && bit_valid) cap_q.push_back(bit_data);
  end

  task automatic summary();
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic hold_line(input bit b, input int n);
    pcm_in = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_seq(input bit bits[$], input int lens[$]);
    int total = 0;
    foreach (lens[i]) total += lens[i];
    cap_q.delete();
    fork
      begin
        repeat (9) @(negedge clk);
        cap_en = 1'b1;
      end
    join_none
    foreach (bits[i]) hold_line(bits[i], lens[i]);
    repeat (8) @(negedge clk);
    cap_en = 1'b0;
    check(cap_q.size() == bits.size(), "R6 R8 strobe count", cap_q.size(), bits.size());
    if (cap_q.size() == bits.size())
      foreach (bits[i]) check(cap_q[i] == bits[i], "R6 R8 recovered bit", cap_q[i], bits[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    bit bits[$];
    int lens[$];
    int gap;
    repeat (4) @(negedge clk);
    check(bit_valid == 0 && bit_data == 0 && sig_present == 0, "R1 outputs in reset",
          {bit_valid, bit_data, sig_present}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(bit_valid == 0 && bit_data == 0 && sig_present == 0, "R1 outputs after release",
          {bit_valid, bit_data, sig_present}, 0);
    cmp_en = 1'b1;
    hold_line(0, 40);

    // R2: a 4-sample pulse is interference
    hold_line(1, HOLD - 1);
    hold_line(0, 60);
    check(sig_present == 0, "R2 short pulse sig_present", sig_present, 0);
    check(bit_data == 0, "R2 short pulse bit_data", bit_data, 0);

    // R3: a 5-sample pulse is accepted
    hold_line(1, HOLD);
    hold_line(0, 12);
    check(sig_present == 1, "R3 held pulse sig_present", sig_present, 1);

    // R7: silence clears the flag
    hold_line(0, IDLE * OSR + 40);
    check(sig_present == 0, "R7 silence clears sig_present", sig_present, 0);

    // R4: free-running spacing during a constant line
    while (!bit_valid) @(negedge clk);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!bit_valid);
    check(gap == OSR, "R4 strobe spacing", gap, OSR);

    // R6: exact 20-clock bits, word 16'hB38D sent MSB first (line low before)
    for (int i = 15; i >= 0; i--) begin
      bits.push_back(1'(16'hB38D >> i));
      lens.push_back(OSR);
    end
    send_seq(bits, lens);

    // R8: jittered bits, runs capped at three
    bits.delete(); lens.delete();
    begin
      bit cur = ~pcm_in;
      int run = 0;
      for (int i = 0; i < 120; i++) begin
        if (i > 0) begin
          if (run >= 3 || $urandom_range(0, 1) == 1) begin
            cur = ~cur; run = 0;
          end
        end
        run++;
        bits.push_back(cur);
        lens.push_back(19 + $urandom_range(0, 2));
      end
    end
    send_seq(bits, lens);

    hold_line(pcm_in, 40);
    summary();
  end
endmodule